// File: doc/BRIEF.md
# Shared Line Buffer Region Partitioner

Two display pipelines, D1 and D2, draw on one line-buffer memory. This block holds the split control word that a host writes, decides from it how many entries belong to D1 and places D2 directly above them, and converts each pipeline's local line-buffer address into a physical memory address. If a local address falls outside the pipeline's region, the block raises an out-of-range flag and gives the memory no address.

The split word has two layers. A staged copy takes host writes and can be read back. An active copy drives the partition. The active copy is loaded from the staged copy only on a frame-start strobe, so a region never moves in the middle of a line. The region size comes either from a 2-bit preset code or from a manual boundary field that holds half of D1's size. D1 always starts at address 0.

Top module: `lbuf_partition`

## Requirements
- R1: After reset, the staged split word reads back as 0, the active split is the even half (boundary DEPTH/2), and both translators show valid and out-of-range low.
- R2: A host write sets the staged word, which reads back at cfg_rdata_o from the next cycle. The active boundary does not change, and translations keep using the old regions, until a frame-start strobe arrives.
- R3: The cycle after frame_start_i, the active split equals the staged word, and split_o shows the new boundary.
- R4: With manual bit 2 clear, code bits 1:0 set D1's size. Code 0 gives DEPTH/2, code 1 gives 3*DEPTH/4, code 2 gives DEPTH (D2 empty), and code 3 gives DEPTH/4.
- R5: With bit 2 set, the code is ignored and D1's size is twice the field at bits [AW+2:4], where AW = log2(DEPTH) (bits 14:4 at DEPTH 4096).
- R6: A D1 request with local address below the boundary returns valid high one cycle later, with the physical address equal to the local address.
- R7: A D2 request with local address below DEPTH minus the boundary returns valid high one cycle later, with the physical address equal to the boundary plus the local address.
- R8: A request outside its region returns out-of-range high, valid low and physical address 0 one cycle later.
- R9: Every access to a region of size zero is out of range. This covers D2 under code 2 and D1 under a manual field of 0.
- R10: A cycle with no request leaves valid and out-of-range low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the staged split word |
| cfg_wdata_i | input | AW+3 | Split word to stage |
| cfg_rdata_o | output | AW+3 | Staged split word readback |
| frame_start_i | input | 1 | Loads the active split from the staged word |
| split_o | output | AW+1 | Active D1 size, which is also D2's base |
| d1_req_i | input | 1 | D1 access request |
| d1_addr_i | input | AW | D1 local address |
| d1_vld_o | output | 1 | D1 translated access valid |
| d1_oor_o | output | 1 | D1 access out of range |
| d1_addr_o | output | AW | D1 physical address |
| d2_req_i | input | 1 | D2 access request |
| d2_addr_i | input | AW | D2 local address |
| d2_vld_o | output | 1 | D2 translated access valid |
| d2_oor_o | output | 1 | D2 access out of range |
| d2_addr_o | output | AW | D2 physical address |

## Verification
The bench builds the block with DEPTH = 64. This puts the manual field at bits 8:4 and shrinks the address space enough that every local address of both pipelines can be swept under each tested split. At that size every preset, both extremes of the manual field (the empty D1 and the largest D1), and the case where manual mode overrides a conflicting preset code can each be checked at every region edge, not just at sampled points.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
  typedef enum logic [1:0] {
    PS_HALF   = 2'd0,
    PS_D1_3Q  = 2'd1,
    PS_D1_ALL = 2'd2,
    PS_D1_1Q  = 2'd3
  } preset_e;

  localparam int unsigned MAN_BIT = 2;
  localparam int unsigned FLD_LSB = 4;
  localparam int unsigned NUM_DISP = 2;
endpackage

// File: rtl/lbuf_cfg_reg.sv
module lbuf_cfg_reg #(
  parameter int unsigned CFG_W = 15,
  parameter int unsigned MAN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             frame_start_i,
  output logic [CFG_W-1:0] staged_o,
  output logic [1:0]       act_code_o,
  output logic             act_man_o,
  output logic [MAN_W-1:0] act_fld_o
);
  import lbuf_pkg::*;

  logic [CFG_W-1:0] staged_q;
  logic [1:0]       code_q;
  logic             man_q;
  logic [MAN_W-1:0] fld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) staged_q <= '0;
    else if (we_i) staged_q <= wdata_i;
  end

  // active copy only moves on frame boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      man_q  <= 1'b0;
      fld_q  <= '0;
    end else if (frame_start_i) begin
      code_q <= staged_q[1:0];
      man_q  <= staged_q[MAN_BIT];
      fld_q  <= staged_q[FLD_LSB +: MAN_W];
    end
  end

  assign staged_o   = staged_q;
  assign act_code_o = code_q;
  assign act_man_o  = man_q;
  assign act_fld_o  = fld_q;

  a_r2_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> staged_q == $past(wdata_i));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(code_q) && $stable(man_q) && $stable(fld_q));
  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> {fld_q, man_q, code_q} ==
      $past({staged_q[FLD_LSB +: MAN_W], staged_q[MAN_BIT], staged_q[1:0]}));
endmodule

// File: rtl/lbuf_range.sv
module lbuf_range #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned MAN_W = AW - 1
) (
  input  logic [1:0]       code_i,
  input  logic             man_i,
  input  logic [MAN_W-1:0] fld_i,
  output logic [AW:0]      d1_size_o,
  output logic [AW:0]      d2_base_o,
  output logic [AW:0]      d2_size_o
);
  import lbuf_pkg::*;

  localparam logic [AW:0] SZ_FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0] SZ_HALF = (AW+1)'(DEPTH / 2);
  localparam logic [AW:0] SZ_QTR  = (AW+1)'(DEPTH / 4);
  localparam logic [AW:0] SZ_3Q   = (AW+1)'(3 * (DEPTH / 4));

  logic [AW:0] preset_sz;

  always_comb begin
    unique case (preset_e'(code_i))
      PS_HALF:   preset_sz = SZ_HALF;
      PS_D1_3Q:  preset_sz = SZ_3Q;
      PS_D1_ALL: preset_sz = SZ_FULL;
      PS_D1_1Q:  preset_sz = SZ_QTR;
      default:   preset_sz = SZ_HALF;
    endcase
  end

  // manual field holds half of the D1 end
  assign d1_size_o = man_i ? {1'b0, fld_i, 1'b0} : preset_sz;
  assign d2_base_o = d1_size_o;
  assign d2_size_o = SZ_FULL - d1_size_o;
endmodule

// File: rtl/lbuf_xlate.sv
module lbuf_xlate #(
  parameter int unsigned AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW:0]   base_i,
  input  logic [AW:0]   size_i,
  input  logic          req_i,
  input  logic [AW-1:0] la_i,
  output logic          vld_o,
  output logic          oor_o,
  output logic [AW-1:0] pa_o
);
  logic [AW:0] sum;
  logic        in_rng;
  logic        vld_q, oor_q;
  logic [AW-1:0] pa_q;

  assign sum    = base_i + {1'b0, la_i};
  assign in_rng = ({1'b0, la_i} < size_i) && !sum[AW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      oor_q <= 1'b0;
      pa_q  <= '0;
    end else begin
      vld_q <= req_i && in_rng;
      oor_q <= req_i && !in_rng;
      pa_q  <= (req_i && in_rng) ? sum[AW-1:0] : '0;
    end
  end

  assign vld_o = vld_q;
  assign oor_o = oor_q;
  assign pa_o  = pa_q;

  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !vld_o && !oor_o);
  a_r8_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o != oor_o);
  a_r9_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i == '0) |=> oor_o && !vld_o);
  a_r8_addr0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oor_o |-> pa_o == '0);
endmodule

// File: rtl/lbuf_partition.sv
module lbuf_partition #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned MAN_W = AW - 1,
  parameter int unsigned CFG_W = lbuf_pkg::FLD_LSB + MAN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic             frame_start_i,
  output logic [AW:0]      split_o,
  input  logic             d1_req_i,
  input  logic [AW-1:0]    d1_addr_i,
  output logic             d1_vld_o,
  output logic             d1_oor_o,
  output logic [AW-1:0]    d1_addr_o,
  input  logic             d2_req_i,
  input  logic [AW-1:0]    d2_addr_i,
  output logic             d2_vld_o,
  output logic             d2_oor_o,
  output logic [AW-1:0]    d2_addr_o
);
  import lbuf_pkg::*;

  logic [1:0]       act_code;
  logic             act_man;
  logic [MAN_W-1:0] act_fld;
  logic [AW:0]      d1_size, d2_base, d2_size;

  lbuf_cfg_reg #(.CFG_W(CFG_W), .MAN_W(MAN_W)) u_reg (
    .clk_i, .rst_ni,
    .we_i          (cfg_we_i),
    .wdata_i       (cfg_wdata_i),
    .frame_start_i (frame_start_i),
    .staged_o      (cfg_rdata_o),
    .act_code_o    (act_code),
    .act_man_o     (act_man),
    .act_fld_o     (act_fld)
  );

  lbuf_range #(.DEPTH(DEPTH), .AW(AW), .MAN_W(MAN_W)) u_range (
    .code_i    (act_code),
    .man_i     (act_man),
    .fld_i     (act_fld),
    .d1_size_o (d1_size),
    .d2_base_o (d2_base),
    .d2_size_o (d2_size)
  );

  assign split_o = d1_size;

  logic [AW:0]   base_a [NUM_DISP];
  logic [AW:0]   size_a [NUM_DISP];
  logic          req_a  [NUM_DISP];
  logic [AW-1:0] la_a   [NUM_DISP];
  logic          vld_a  [NUM_DISP];
  logic          oor_a  [NUM_DISP];
  logic [AW-1:0] pa_a   [NUM_DISP];

  assign base_a[0] = '0;
  assign size_a[0] = d1_size;
  assign req_a[0]  = d1_req_i;
  assign la_a[0]   = d1_addr_i;
  assign base_a[1] = d2_base;
  assign size_a[1] = d2_size;
  assign req_a[1]  = d2_req_i;
  assign la_a[1]   = d2_addr_i;

  for (genvar g = 0; g < NUM_DISP; g++) begin : g_disp
    lbuf_xlate #(.AW(AW)) u_xl (
      .clk_i, .rst_ni,
      .base_i (base_a[g]),
      .size_i (size_a[g]),
      .req_i  (req_a[g]),
      .la_i   (la_a[g]),
      .vld_o  (vld_a[g]),
      .oor_o  (oor_a[g]),
      .pa_o   (pa_a[g])
    );
  end

  assign d1_vld_o  = vld_a[0];
  assign d1_oor_o  = oor_a[0];
  assign d1_addr_o = pa_a[0];
  assign d2_vld_o  = vld_a[1];
  assign d2_oor_o  = oor_a[1];
  assign d2_addr_o = pa_a[1];

  a_r4_fit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d1_size + d2_size) == (AW+1)'(DEPTH) && d1_size <= (AW+1)'(DEPTH));
endmodule

// File: tb/lbuf_partition_test.sv
module lbuf_partition_test;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int CFG_W = 9;
  localparam int NCFG  = 8;

  localparam logic [CFG_W-1:0] CFG_T [NCFG] = '{
    9'h000, 9'h001, 9'h002, 9'h003, 9'h054, 9'h1F4, 9'h004, 9'h086};
  localparam int BND_T [NCFG] = '{32, 48, 64, 16, 10, 62, 0, 16};
  localparam string REQ_T [NCFG] = '{"R4", "R4", "R4", "R4", "R5", "R5", "R5", "R5"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic [CFG_W-1:0] cfg_rdata;
  logic frame_start = 1'b0;
  logic [AW:0] split;
  logic d1_req = 1'b0, d2_req = 1'b0;
  logic [AW-1:0] d1_addr = '0, d2_addr = '0;
  logic d1_vld, d1_oor, d2_vld, d2_oor;
  logic [AW-1:0] d1_pa, d2_pa;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lbuf_partition #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .frame_start_i(frame_start), .split_o(split),
    .d1_req_i(d1_req), .d1_addr_i(d1_addr),
    .d1_vld_o(d1_vld), .d1_oor_o(d1_oor), .d1_addr_o(d1_pa),
    .d2_req_i(d2_req), .d2_addr_i(d2_addr),
    .d2_vld_o(d2_vld), .d2_oor_o(d2_oor), .d2_addr_o(d2_pa)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [CFG_W-1:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  // one access on both pipelines; results sampled one cycle later
  task automatic access(input int a1, input int a2, input int bnd, input string rq);
    int sz2;
    bit in1, in2;
    int e1, e2;
    sz2 = DEPTH - bnd;
    in1 = a1 < bnd;
    in2 = a2 < sz2;
    e1 = in1 ? a1 : 0;
    e2 = in2 ? bnd + a2 : 0;
    @(negedge clk);
    d1_req = 1'b1; d1_addr = AW'(a1);
    d2_req = 1'b1; d2_addr = AW'(a2);
    @(negedge clk);
    d1_req = 1'b0; d2_req = 1'b0;
    // R6 R8 R9: D1 side
    check(d1_vld == in1 && d1_oor == !in1 && int'(d1_pa) == e1,
          {rq, "/R6/R8/R9 d1"}, {d1_vld, d1_oor, 6'(d1_pa)}, {in1, !in1, 6'(e1)});
    // R7 R8 R9: D2 side
    check(d2_vld == in2 && d2_oor == !in2 && int'(d2_pa) == e2,
          {rq, "/R7/R8/R9 d2"}, {d2_vld, d2_oor, 6'(d2_pa)}, {in2, !in2, 6'(e2)});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cfg_rdata == '0, "R1 rdata", cfg_rdata, 0);
    check(int'(split) == 32, "R1 split", split, 32);
    check(!d1_vld && !d1_oor && !d2_vld && !d2_oor, "R1 flags",
          {d1_vld, d1_oor, d2_vld, d2_oor}, 0);

    // R2 staged write does not disturb active regions
    wr(9'h002);
    check(cfg_rdata == 9'h002, "R2 readback", cfg_rdata, 9'h002);
    check(int'(split) == 32, "R2 split held", split, 32);
    access(31, 31, 32, "R2");
    // R3 adopt at frame start
    frame();
    check(int'(split) == 64, "R3 split", split, 64);
    access(31, 0, 64, "R3");

    // table walk over presets and manual splits
    for (int i = 0; i < NCFG; i++) begin
      wr(CFG_T[i]);
      frame();
      check(cfg_rdata == CFG_T[i], {REQ_T[i], " readback"}, cfg_rdata, CFG_T[i]);
      check(int'(split) == BND_T[i], {REQ_T[i], " split"}, split, BND_T[i]);
      for (int a = 0; a < DEPTH; a++) access(a, a, BND_T[i], REQ_T[i]);
      // R10 no request: flags stay low
      @(negedge clk);
      check(!d1_vld && !d1_oor && !d2_vld && !d2_oor, "R10 idle",
            {d1_vld, d1_oor, d2_vld, d2_oor}, 0);
    end

    // R2/R3: write during frame without re-strobe keeps old split
    wr(9'h003);
    check(int'(split) == 16, "R2 held manual", split, 16);
    frame();
    check(int'(split) == 16, "R3 preset 3", split, 16);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule